// File: doc/BRIEF.md
# Dual-Line Asynchronous Serial Frame Monitor

This block listens, without driving anything, to the two lines of an asynchronous serial link: the receive line and the transmit line. Each line has its own frame decoder. A decoder waits for the line to fall from its high idle level. It then samples each bit in the middle of its bit period and turns every field of the frame into a typed event. The fields are the start bit, the assembled data word, the parity bit and the first stop bit. Events from both lines leave through one registered output strobe. Each event carries a direction tag, so one stream of records can feed a logger or a protocol checker.

The frame format is set at run time. The bit period is given in clock cycles as a fixed-point value with a fractional part, so sample instants stay centred even when the clock is not an integer multiple of the baud rate. Other settings are the data width (5 to 9 bits), the order of the data bits on the wire, one of five parity modes, and one of four stop lengths (0.5, 1, 1.5 or 2 bit periods). Faults are reported rather than dropped. A start bit that reads high, a parity mismatch and a low stop bit each produce their own event type. A faulty start does not abort the frame. Each line passes through a two-stage synchronizer before its edge detector.

Top module: `uart_dual_monitor`

## Requirements
- R1: After reset, and while both lines stay high, `ev_valid` stays low.
- R2: A high-to-low transition on an idle line starts a frame. The start bit is sampled half a bit period after the edge. A low sample gives an event of type 0 with value 0. The direction bit is 0 for the receive line and 1 for the transmit line.
- R3: Data bit k of the frame is sampled k+1 bit periods after the start sample. `cfg_data_bits` (5..9) sets the word length. After the last data bit, one event of type 1 reports the word, with unused upper bits zero. With `cfg_msb_first`=0, the first bit received is bit 0 of the word. With `cfg_msb_first`=1, it is the word's top bit.
- R4: Odd parity (`cfg_parity`=1) and even parity (`cfg_parity`=2) count the ones in the data bits plus the parity bit. A correct parity bit gives type 2 with the bit as value. With `cfg_check_parity`=1, a wrong bit gives type 6, with `ev_par_exp` holding the expected bit and `ev_par_got` the received bit.
- R5: Mark parity (`cfg_parity`=3) expects a parity bit of 1. Space parity (`cfg_parity`=4) expects 0. A mismatch is reported as in R4.
- R6: With `cfg_parity`=0 the frame has no parity bit, no event of type 2 or 6 is produced, and the stop bit directly follows the last data bit.
- R7: A first stop bit that samples high gives type 3 with value 1. One that samples low gives type 5 with value 0.
- R8: A start bit that samples high gives type 4 with value 1, and the data, parity and stop fields of that frame are still decoded.
- R9: With `cfg_check_parity`=0, a parity mismatch is reported as type 2 carrying the received bit, never as type 6.
- R10: A line is not re-armed until its stop period ends. With `cfg_stop` codes 0/1/2/3 (0.5/1/1.5/2 bit periods), this is 0/0.5/1/1.5 bit periods after the stop sample. A falling edge before that point starts no frame.
- R11: The two lines decode independently. When both produce an event in the same cycle, the receive event is output first and the transmit event follows in the next cycle.
- R12: `cfg_bit_period` is unsigned fixed point with 4 fraction bits. A non-integer period such as 16.5 cycles decodes a full 9-bit frame with parity and two stop bits without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Receive serial line (idle high) |
| tx_line | input | 1 | Transmit serial line (idle high) |
| cfg_bit_period | input | 16 | Bit period in clock cycles, 12.4 fixed point |
| cfg_data_bits | input | 4 | Data bits per frame, 5..9 (clamped) |
| cfg_parity | input | 3 | 0 none, 1 odd, 2 even, 3 mark, 4 space |
| cfg_stop | input | 2 | Stop length: 0 half, 1 one, 2 one and a half, 3 two |
| cfg_msb_first | input | 1 | 1: first data bit is the word's top bit |
| cfg_check_parity | input | 1 | 1: mismatches produce parity-error events |
| ev_valid | output | 1 | One-cycle strobe: an event record is present |
| ev_type | output | 3 | 0 start, 1 data, 2 parity, 3 stop, 4 bad start, 5 bad stop, 6 parity error |
| ev_dir | output | 1 | 0 receive line, 1 transmit line |
| ev_value | output | 9 | Bit value or assembled data word |
| ev_par_exp | output | 1 | Expected parity bit (parity-error events) |
| ev_par_got | output | 1 | Received parity bit (parity-error events) |

## Verification
A table of frames covers word widths 5 to 9 in both bit orders, under every parity mode, with correct and corrupted parity bits. Asymmetric data values separate a reversed word from a correct one. Flipped parity bits with checking on and off separate the expected-versus-received report from the plain parity report. Frames with a low stop bit, or with a start glitch that rises before mid-bit, show that the fault events appear while the remaining fields are still decoded. One frame uses a 16.5-cycle period and shows that the fractional accumulator keeps samples centred. Directed tests then drive both lines with the same timing to check receive-first ordering with a one-cycle gap. They also place a short low pulse inside the trailing stop window under the two-bit and half-bit stop settings: only the half-bit setting may turn that pulse into a new frame.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;

  localparam int DATA_MAX = 9;

  typedef enum logic [2:0] {
    EV_START     = 3'd0,
    EV_DATA      = 3'd1,
    EV_PARITY    = 3'd2,
    EV_STOP      = 3'd3,
    EV_BAD_START = 3'd4,
    EV_BAD_STOP  = 3'd5,
    EV_PAR_ERR   = 3'd6
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_GUARD
  } chan_state_e;

  localparam logic [2:0] PAR_NONE  = 3'd0;
  localparam logic [2:0] PAR_ODD   = 3'd1;
  localparam logic [2:0] PAR_EVEN  = 3'd2;
  localparam logic [2:0] PAR_MARK  = 3'd3;
  localparam logic [2:0] PAR_SPACE = 3'd4;

  typedef struct packed {
    logic                fire;
    ev_kind_e            kind;
    logic [DATA_MAX-1:0] value;
    logic                par_exp;
    logic                par_got;
  } chan_ev_t;

endpackage

// File: rtl/uart_mon_sync.sv
module uart_mon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic level,
  output logic fall
);

  logic [STAGES-1:0] shreg;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '1;
      prev_q <= 1'b1;
    end else begin
      shreg  <= {shreg[STAGES-2:0], line_in};
      prev_q <= shreg[STAGES-1];
    end
  end

  assign level = shreg[STAGES-1];
  assign fall  = prev_q & ~shreg[STAGES-1];

endmodule

// File: rtl/uart_mon_chan.sv
module uart_mon_chan
  import uart_mon_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    level,
  input  logic                    fall,
  input  logic [INT_W+FRAC_W-1:0] cfg_period,
  input  logic [3:0]              cfg_bits,
  input  logic [2:0]              cfg_par,
  input  logic [1:0]              cfg_stop,
  input  logic                    cfg_msb,
  input  logic                    cfg_chk,
  output chan_ev_t                ev
);

  localparam int PER_W = INT_W + FRAC_W;
  localparam int ACC_W = PER_W + 4;
  localparam int CNT_W = ACC_W - FRAC_W;

  chan_state_e         state;
  logic [CNT_W-1:0]    cnt;
  logic [ACC_W-1:0]    target;
  logic [3:0]          idx;
  logic [DATA_MAX-1:0] word;
  logic [DATA_MAX-1:0] word_nx;
  logic [ACC_W-1:0]    period_w;
  logic [ACC_W-1:0]    half_w;
  logic [ACC_W-1:0]    tail_w;
  logic                due;
  logic                par_exp;
  logic                last_bit;

  assign period_w = ACC_W'(cfg_period);
  assign half_w   = ACC_W'(cfg_period >> 1);
  assign due      = ({cnt, {FRAC_W{1'b0}}} >= target);
  assign last_bit = (idx == (cfg_bits - 4'd1));

  // Extra wait after the stop sample until the stop period has elapsed.
  always_comb begin
    case (cfg_stop)
      2'd0:    tail_w = '0;
      2'd1:    tail_w = half_w;
      2'd2:    tail_w = period_w;
      default: tail_w = period_w + half_w;
    endcase
  end

  always_comb begin
    word_nx = word;
    if (cfg_msb) word_nx = {word[DATA_MAX-2:0], level};
    else         word_nx[idx] = level;
  end

  always_comb begin
    case (cfg_par)
      PAR_ODD:   par_exp = ~^word;
      PAR_EVEN:  par_exp = ^word;
      PAR_MARK:  par_exp = 1'b1;
      default:   par_exp = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      target <= '0;
      idx    <= '0;
      word   <= '0;
      ev     <= '0;
    end else begin
      ev.fire <= 1'b0;
      if (state == ST_IDLE) begin
        if (fall) begin
          state  <= ST_START;
          cnt    <= CNT_W'(1);
          target <= half_w;
          idx    <= '0;
          word   <= '0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (due) begin
          target <= target + period_w;
          case (state)
            ST_START: begin
              ev.fire    <= 1'b1;
              ev.kind    <= level ? EV_BAD_START : EV_START;
              ev.value   <= DATA_MAX'(level);
              ev.par_exp <= 1'b0;
              ev.par_got <= 1'b0;
              state      <= ST_DATA;
            end
            ST_DATA: begin
              word <= word_nx;
              idx  <= idx + 4'd1;
              if (last_bit) begin
                ev.fire    <= 1'b1;
                ev.kind    <= EV_DATA;
                ev.value   <= word_nx;
                ev.par_exp <= 1'b0;
                ev.par_got <= 1'b0;
                state      <= (cfg_par == PAR_NONE) ? ST_STOP : ST_PAR;
              end
            end
            ST_PAR: begin
              ev.fire    <= 1'b1;
              ev.kind    <= (cfg_chk && (level != par_exp)) ? EV_PAR_ERR : EV_PARITY;
              ev.value   <= DATA_MAX'(level);
              ev.par_exp <= par_exp;
              ev.par_got <= level;
              state      <= ST_STOP;
            end
            ST_STOP: begin
              ev.fire    <= 1'b1;
              ev.kind    <= level ? EV_STOP : EV_BAD_STOP;
              ev.value   <= DATA_MAX'(level);
              ev.par_exp <= 1'b0;
              ev.par_got <= 1'b0;
              target     <= target + tail_w;
              state      <= ST_GUARD;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/uart_mon_merge.sv
module uart_mon_merge
  import uart_mon_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  chan_ev_t            rx_ev,
  input  chan_ev_t            tx_ev,
  output logic                ev_valid,
  output logic [2:0]          ev_type,
  output logic                ev_dir,
  output logic [DATA_MAX-1:0] ev_value,
  output logic                ev_par_exp,
  output logic                ev_par_got
);

  chan_ev_t held;
  logic     held_v;
  chan_ev_t pick;
  logic     pick_dir;
  logic     pick_v;

  always_comb begin
    pick     = rx_ev;
    pick_dir = 1'b0;
    pick_v   = 1'b0;
    if (rx_ev.fire) begin
      pick_v = 1'b1;
    end else if (held_v) begin
      pick     = held;
      pick_dir = 1'b1;
      pick_v   = 1'b1;
    end else if (tx_ev.fire) begin
      pick     = tx_ev;
      pick_dir = 1'b1;
      pick_v   = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= '0;
      held_v     <= 1'b0;
      ev_valid   <= 1'b0;
      ev_type    <= '0;
      ev_dir     <= 1'b0;
      ev_value   <= '0;
      ev_par_exp <= 1'b0;
      ev_par_got <= 1'b0;
    end else begin
      ev_valid <= pick_v;
      if (pick_v) begin
        ev_type    <= pick.kind;
        ev_dir     <= pick_dir;
        ev_value   <= pick.value;
        ev_par_exp <= pick.par_exp;
        ev_par_got <= pick.par_got;
      end
      if (tx_ev.fire && (rx_ev.fire || held_v)) begin
        held   <= tx_ev;
        held_v <= 1'b1;
      end else if (!rx_ev.fire && held_v) begin
        held_v <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/uart_dual_monitor.sv
module uart_dual_monitor
  import uart_mon_pkg::*;
#(
  parameter int INT_W       = 12,
  parameter int FRAC_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_line,
  input  logic                    tx_line,
  input  logic [INT_W+FRAC_W-1:0] cfg_bit_period,
  input  logic [3:0]              cfg_data_bits,
  input  logic [2:0]              cfg_parity,
  input  logic [1:0]              cfg_stop,
  input  logic                    cfg_msb_first,
  input  logic                    cfg_check_parity,
  output logic                    ev_valid,
  output logic [2:0]              ev_type,
  output logic                    ev_dir,
  output logic [DATA_MAX-1:0]     ev_value,
  output logic                    ev_par_exp,
  output logic                    ev_par_got
);

  localparam int NUM_CH = 2;

  logic [NUM_CH-1:0] lines;
  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] fal;
  logic [NUM_CH-1:0] ch_fire;
  chan_ev_t          ch_ev [NUM_CH];
  logic [3:0]        bits_eff;

  assign lines    = {tx_line, rx_line};
  assign bits_eff = (cfg_data_bits < 4'd5) ? 4'd5 :
                    (cfg_data_bits > 4'd9) ? 4'd9 : cfg_data_bits;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    uart_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .line_in (lines[g]),
      .level   (lvl[g]),
      .fall    (fal[g])
    );
    uart_mon_chan #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .level      (lvl[g]),
      .fall       (fal[g]),
      .cfg_period (cfg_bit_period),
      .cfg_bits   (bits_eff),
      .cfg_par    (cfg_parity),
      .cfg_stop   (cfg_stop),
      .cfg_msb    (cfg_msb_first),
      .cfg_chk    (cfg_check_parity),
      .ev         (ch_ev[g])
    );
    assign ch_fire[g] = ch_ev[g].fire;
  end

  uart_mon_merge u_merge (
    .clk        (clk),
    .rst        (rst),
    .rx_ev      (ch_ev[0]),
    .tx_ev      (ch_ev[1]),
    .ev_valid   (ev_valid),
    .ev_type    (ev_type),
    .ev_dir     (ev_dir),
    .ev_value   (ev_value),
    .ev_par_exp (ev_par_exp),
    .ev_par_got (ev_par_got)
  );

endmodule

// File: rtl/uart_mon_checker.sv
module uart_mon_checker (
  input logic       clk,
  input logic       rst,
  input logic [1:0] ch_fire,
  input logic [3:0] cfg_data_bits,
  input logic [2:0] cfg_parity,
  input logic       cfg_check_parity,
  input logic       ev_valid,
  input logic [2:0] ev_type,
  input logic       ev_dir,
  input logic [8:0] ev_value
);

  // R11: simultaneous channel events leave receive first, transmit next
  a_r11_rx_first: assert property (@(posedge clk) disable iff (rst)
    (ch_fire == 2'b11) |=> (ev_valid && !ev_dir));
  a_r11_tx_next: assert property (@(posedge clk) disable iff (rst)
    (ch_fire == 2'b11) |=> ##1 (ev_valid && ev_dir));

  // R3: data word has no bits above the configured width
  a_r3_word_width: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_type == 3'd1) |-> ((ev_value >> cfg_data_bits) == 9'd0));

  // R2 and R8: start events carry the value that selects their type
  a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_type == 3'd0) |-> (ev_value == 9'd0));
  a_r8_bad_start_high: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_type == 3'd4) |-> (ev_value == 9'd1));

  // R7: stop events carry the sampled level
  a_r7_stop_high: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_type == 3'd3) |-> (ev_value == 9'd1));
  a_r7_bad_stop_low: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_type == 3'd5) |-> (ev_value == 9'd0));

  // R6: no parity events when parity is off
  a_r6_no_parity: assert property (@(posedge clk) disable iff (rst)
    (cfg_parity == 3'd0) |-> !(ev_valid && (ev_type == 3'd2 || ev_type == 3'd6)));

  // R9: checking disabled never yields a parity-error event
  a_r9_no_perr: assert property (@(posedge clk) disable iff (rst)
    !cfg_check_parity |-> !(ev_valid && ev_type == 3'd6));

  // R2: event type stays in the defined range
  a_r2_type_range: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> (ev_type <= 3'd6));

endmodule

bind uart_dual_monitor uart_mon_checker u_chk (
  .clk              (clk),
  .rst              (rst),
  .ch_fire          (ch_fire),
  .cfg_data_bits    (bits_eff),
  .cfg_parity       (cfg_parity),
  .cfg_check_parity (cfg_check_parity),
  .ev_valid         (ev_valid),
  .ev_type          (ev_type),
  .ev_dir           (ev_dir),
  .ev_value         (ev_value)
);

// File: tb/tb_uart_dual_monitor.sv
module tb_uart_dual_monitor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_line = 1'b1;
  logic        tx_line = 1'b1;
  logic [15:0] cfg_bit_period = 16'd256;
  logic [3:0]  cfg_data_bits = 4'd8;
  logic [2:0]  cfg_parity = 3'd0;
  logic [1:0]  cfg_stop = 2'd1;
  logic        cfg_msb_first = 1'b0;
  logic        cfg_check_parity = 1'b1;
  logic        ev_valid;
  logic [2:0]  ev_type;
  logic        ev_dir;
  logic [8:0]  ev_value;
  logic        ev_par_exp;
  logic        ev_par_got;

  always #5 clk = ~clk;

  uart_dual_monitor dut (
    .clk(clk), .rst(rst), .rx_line(rx_line), .tx_line(tx_line),
    .cfg_bit_period(cfg_bit_period), .cfg_data_bits(cfg_data_bits),
    .cfg_parity(cfg_parity), .cfg_stop(cfg_stop), .cfg_msb_first(cfg_msb_first),
    .cfg_check_parity(cfg_check_parity), .ev_valid(ev_valid), .ev_type(ev_type),
    .ev_dir(ev_dir), .ev_value(ev_value), .ev_par_exp(ev_par_exp), .ev_par_got(ev_par_got)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int cyc = 0;

  // capture of output events
  int         cap_n = 0;
  logic [2:0] cap_type [256];
  logic       cap_dir  [256];
  logic [8:0] cap_val  [256];
  logic       cap_pe   [256];
  logic       cap_pg   [256];
  int         cap_cyc  [256];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && ev_valid && cap_n < 256) begin
      cap_type[cap_n] = ev_type;
      cap_dir[cap_n]  = ev_dir;
      cap_val[cap_n]  = ev_value;
      cap_pe[cap_n]   = ev_par_exp;
      cap_pg[cap_n]   = ev_par_got;
      cap_cyc[cap_n]  = cyc;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // expected events
  int         exp_n;
  logic [2:0] exp_type [8];
  logic [8:0] exp_val  [8];
  logic       exp_pe   [8];
  logic       exp_pg   [8];

  function automatic logic [8:0] mask_w(input logic [8:0] d, input int w);
    return d & 9'((1 << w) - 1);
  endfunction

  function automatic logic good_par(input logic [8:0] dm, input int pm);
    case (pm)
      1: return ~^dm;
      2: return ^dm;
      3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [12:0] mkseq(input logic [8:0] d, input int w, input bit msb,
                                        input int pm, input bit flip, input bit sv);
    logic [12:0] s;
    logic [8:0]  dm;
    int          k;
    s  = '1;
    dm = mask_w(d, w);
    s[0] = 1'b0;
    for (int i = 0; i < w; i++) s[1+i] = msb ? dm[w-1-i] : dm[i];
    k = 1 + w;
    if (pm != 0) begin
      s[k] = good_par(dm, pm) ^ flip;
      k++;
    end
    s[k] = sv;
    return s;
  endfunction

  task automatic build_exp(input logic [8:0] d, input int w, input int pm, input bit flip,
                           input bit bst, input bit sv, input bit chk);
    logic [8:0] dm;
    logic       gp;
    dm = mask_w(d, w);
    exp_n = 0;
    exp_type[exp_n] = bst ? 3'd4 : 3'd0; exp_val[exp_n] = bst ? 9'd1 : 9'd0;
    exp_pe[exp_n] = 0; exp_pg[exp_n] = 0; exp_n++;
    exp_type[exp_n] = 3'd1; exp_val[exp_n] = dm; exp_pe[exp_n] = 0; exp_pg[exp_n] = 0; exp_n++;
    if (pm != 0) begin
      gp = good_par(dm, pm);
      exp_type[exp_n] = (flip && chk) ? 3'd6 : 3'd2;
      exp_val[exp_n]  = 9'(gp ^ flip);
      exp_pe[exp_n]   = gp;
      exp_pg[exp_n]   = gp ^ flip;
      exp_n++;
    end
    exp_type[exp_n] = sv ? 3'd3 : 3'd5; exp_val[exp_n] = 9'(sv);
    exp_pe[exp_n] = 0; exp_pg[exp_n] = 0; exp_n++;
  endtask

  task automatic send_frame(input bit en_rx, input bit en_tx,
                            input logic [8:0] d_rx, input logic [8:0] d_tx,
                            input int w, input bit msb, input int pm, input bit flip,
                            input bit bst, input bit sv, input int p2, input bit glitch);
    logic [12:0] srx, stx;
    int n, total, k, off;
    logic vr, vt;
    srx = mkseq(d_rx, w, msb, pm, flip, sv);
    stx = mkseq(d_tx, w, msb, pm, flip, sv);
    n = 1 + w + ((pm != 0) ? 1 : 0) + 2;
    total = (n * p2) / 2 + (14 * p2) / 2;
    for (int c = 0; c < total; c++) begin
      k = (c * 2) / p2;
      vr = (k < n) ? srx[k] : 1'b1;
      vt = (k < n) ? stx[k] : 1'b1;
      if (bst && k == 0 && c >= 3) begin vr = 1'b1; vt = 1'b1; end
      off = c - ((n - 1) * p2) / 2;
      if (glitch && off >= 3 && off <= 5) begin vr = 1'b0; vt = 1'b0; end
      @(negedge clk);
      rx_line <= en_rx ? vr : 1'b1;
      tx_line <= en_tx ? vt : 1'b1;
    end
  endtask

  task automatic compare(input int base, input bit dir, input string req);
    check(cap_n - base == exp_n, req, "event count", cap_n - base, exp_n);
    for (int i = 0; i < exp_n && base + i < cap_n; i++) begin
      check(cap_type[base+i] == exp_type[i], req, "type", cap_type[base+i], exp_type[i]);
      check(cap_val[base+i] == exp_val[i], req, "value", cap_val[base+i], exp_val[i]);
      check(cap_dir[base+i] == dir, req, "dir", cap_dir[base+i], dir);
      if (exp_type[i] == 3'd6) begin
        check(cap_pe[base+i] == exp_pe[i], req, "expected parity", cap_pe[base+i], exp_pe[i]);
        check(cap_pg[base+i] == exp_pg[i], req, "received parity", cap_pg[base+i], exp_pg[i]);
      end
    end
  endtask

  typedef struct packed {
    logic       dir;
    logic [3:0] w;
    logic       msb;
    logic [2:0] pm;
    logic [8:0] d;
    logic       flip;
    logic       bst;
    logic       sv;
    logic [1:0] sc;
    logic       chk;
    logic [7:0] p2;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 4'd8, 1'b0, 3'd0, 9'h0A5, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 8'd32},
    '{1'b1, 4'd8, 1'b1, 3'd0, 9'h00D, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 8'd32},
    '{1'b0, 4'd5, 1'b0, 3'd1, 9'h013, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 8'd32},
    '{1'b1, 4'd9, 1'b0, 3'd2, 9'h1A7, 1'b1, 1'b0, 1'b1, 2'd2, 1'b1, 8'd32},
    '{1'b0, 4'd7, 1'b1, 3'd3, 9'h055, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 8'd32},
    '{1'b1, 4'd6, 1'b0, 3'd4, 9'h029, 1'b1, 1'b0, 1'b1, 2'd0, 1'b1, 8'd32},
    '{1'b0, 4'd8, 1'b0, 3'd1, 9'h0C3, 1'b1, 1'b0, 1'b1, 2'd1, 1'b0, 8'd32},
    '{1'b1, 4'd8, 1'b0, 3'd0, 9'h071, 1'b0, 1'b0, 1'b0, 2'd1, 1'b1, 8'd32},
    '{1'b0, 4'd8, 1'b0, 3'd2, 9'h05E, 1'b0, 1'b1, 1'b1, 2'd1, 1'b1, 8'd32},
    '{1'b0, 4'd9, 1'b1, 3'd1, 9'h12D, 1'b0, 1'b0, 1'b1, 2'd3, 1'b1, 8'd33}
  };

  function automatic string tag_of(input int i);
    case (i)
      0: return "R2/R3/R6";
      1: return "R3 msb-first";
      2: return "R4 odd";
      3: return "R4 even error";
      4: return "R5 mark";
      5: return "R5 space error";
      6: return "R9 unchecked";
      7: return "R7 bad stop";
      8: return "R8 bad start";
      default: return "R12 fractional";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int base;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: quiet after reset with idle lines
    check(ev_valid == 1'b0, "R1", "ev_valid after reset", ev_valid, 0);
    repeat (60) @(negedge clk);
    check(cap_n == 0, "R1", "events while idle", cap_n, 0);

    for (int i = 0; i < NV; i++) begin
      cfg_bit_period   = 16'(VEC[i].p2) << 3;
      cfg_data_bits    = VEC[i].w;
      cfg_parity       = VEC[i].pm;
      cfg_stop         = VEC[i].sc;
      cfg_msb_first    = VEC[i].msb;
      cfg_check_parity = VEC[i].chk;
      build_exp(VEC[i].d, int'(VEC[i].w), int'(VEC[i].pm), VEC[i].flip,
                VEC[i].bst, VEC[i].sv, VEC[i].chk);
      base = cap_n;
      send_frame(!VEC[i].dir, VEC[i].dir, VEC[i].d, VEC[i].d, int'(VEC[i].w), VEC[i].msb,
                 int'(VEC[i].pm), VEC[i].flip, VEC[i].bst, VEC[i].sv, int'(VEC[i].p2), 1'b0);
      compare(base, VEC[i].dir, tag_of(i));
    end

    // R11: both lines at once, receive first, transmit one cycle later
    cfg_bit_period = 16'd256; cfg_data_bits = 4'd8; cfg_parity = 3'd0;
    cfg_stop = 2'd1; cfg_msb_first = 1'b0; cfg_check_parity = 1'b1;
    base = cap_n;
    send_frame(1'b1, 1'b1, 9'h03C, 9'h0B1, 8, 1'b0, 0, 1'b0, 1'b0, 1'b1, 32, 1'b0);
    check(cap_n - base == 6, "R11", "paired event count", cap_n - base, 6);
    if (cap_n - base == 6) begin
      for (int j = 0; j < 3; j++) begin
        check(cap_dir[base+2*j] == 1'b0, "R11", "first of pair dir", cap_dir[base+2*j], 0);
        check(cap_dir[base+2*j+1] == 1'b1, "R11", "second of pair dir", cap_dir[base+2*j+1], 1);
        check(cap_cyc[base+2*j+1] == cap_cyc[base+2*j] + 1, "R11", "pair spacing",
              cap_cyc[base+2*j+1] - cap_cyc[base+2*j], 1);
        check(cap_type[base+2*j] == cap_type[base+2*j+1], "R11", "pair types",
              cap_type[base+2*j+1], cap_type[base+2*j]);
      end
      check(cap_val[base+2] == 9'h03C, "R11", "rx data", cap_val[base+2], 9'h03C);
      check(cap_val[base+3] == 9'h0B1, "R11", "tx data", cap_val[base+3], 9'h0B1);
    end

    // R10: low pulse inside the two-bit stop window starts nothing
    cfg_stop = 2'd3;
    base = cap_n;
    send_frame(1'b1, 1'b0, 9'h05A, 9'h000, 8, 1'b0, 0, 1'b0, 1'b0, 1'b1, 32, 1'b1);
    check(cap_n - base == 3, "R10", "events with 2 stop bits", cap_n - base, 3);

    // R10: same pulse after a half-bit stop window opens a new (bad-start) frame
    cfg_stop = 2'd0;
    base = cap_n;
    send_frame(1'b1, 1'b0, 9'h05A, 9'h000, 8, 1'b0, 0, 1'b0, 1'b0, 1'b1, 32, 1'b1);
    check(cap_n - base == 6, "R10", "events with half stop", cap_n - base, 6);
    if (cap_n - base == 6) begin
      check(cap_type[base+3] == 3'd4, "R10", "re-armed start type", cap_type[base+3], 4);
      check(cap_val[base+4] == 9'h0FF, "R10", "re-armed data", cap_val[base+4], 9'h0FF);
    end

    repeat (20) @(negedge clk);
    check(ev_valid == 1'b0, "R1", "quiet at end", ev_valid, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule